// File: doc/BRIEF.md
# Dual-Clock LIFO Stack

This block is a last-in first-out stack whose producer and consumer run on two unrelated clocks. All storage and the stack pointer live in the consumer (pop) clock domain. A producer hands a word over through a toggle request and acknowledge handshake. The word is held in a register until the pop domain has seen the request through a synchronizer and applied it. The producer sees a ready output that stays low from an accepted push until the acknowledge returns.

Because a push reaches the stack several pop-clock cycles after it was issued, a push and a pop that arrive close together need a fixed rule. A push that reaches the pop domain in the same cycle as a local pop request is applied first, so that pop returns the word just pushed and the depth does not change. Every pop result carries a one-cycle valid strobe. A pop on an empty stack gives a one-cycle underflow pulse instead of data. A push that reaches a full stack is discarded and gives a one-cycle overflow pulse.

Top module: `dual_clock_stack`

## Requirements
- R1: After reset, empty is 1, full is 0, pop_valid, underflow and overflow are 0, and push_ready is 1.
- R2: A push is accepted when push_req and push_ready are both 1 at a push-clock edge. push_ready is 0 after that edge and returns to 1 only once the word has been applied in the pop domain. A push_req while push_ready is 0 is ignored and stores no word.
- R3: Pops return words in the reverse of the order in which they were applied to the stack.
- R4: A pop_req with at least one word stored gives pop_valid = 1 for exactly one pop-clock cycle. The strobe appears on the cycle after the edge that sampled the request, and pop_data then holds the top word.
- R5: A pop_req on an empty stack, with no push arriving in that cycle, gives underflow = 1 for one cycle and pop_valid = 0. The stored contents do not change.
- R6: A push that reaches the pop domain while the stack holds DEPTH words is discarded and gives overflow = 1 for one cycle. The stored words are unchanged.
- R7: A push that reaches the pop domain in the same cycle as a pop_req is applied first. That pop returns the pushed word with pop_valid = 1, and the depth is unchanged. This also holds on an empty stack, where no underflow is raised.
- R8: empty is 1 exactly when zero words are stored, and full is 1 exactly when DEPTH words are stored.
- R9: On an empty stack with no pops, empty falls no more than 6 pop-clock cycles after the push-clock edge that accepted a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Push-side clock |
| wr_rst | input | 1 | Push-side synchronous active-high reset |
| push_req | input | 1 | Push request, taken when push_ready is 1 |
| push_data | input | DATA_W | Word to push |
| push_ready | output | 1 | Push side may issue a new push |
| rd_clk | input | 1 | Pop-side clock, owns the stack |
| rd_rst | input | 1 | Pop-side synchronous active-high reset |
| pop_req | input | 1 | Pop request, one per cycle it is high |
| pop_data | output | DATA_W | Popped word, meaningful while pop_valid is 1 |
| pop_valid | output | 1 | One-cycle strobe for a returned word |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| underflow | output | 1 | One-cycle pulse: pop on an empty stack |
| overflow | output | 1 | One-cycle pulse: push dropped on a full stack |

## Verification
The assertions assume that each reset is held for several cycles of its own clock from time zero, and that pop_req is sampled only on pop-clock edges. They also assume that push_data does not matter while push_ready is 0, because the word crossing the boundary is the held copy. The stimulus changes every input on the falling edge of its own clock. Apart from the same-cycle ordering test, the bench waits for push_ready to return before it issues a pop, so the stack order it expects follows from the handshake alone. In the ordering test, pop_req stays high across the whole arrival window, which makes the same-cycle case certain without knowing the synchronizer phase.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    // Action taken by the pop-domain stack in one cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_BYPASS,
        OP_DROP,
        OP_DROP_POP,
        OP_UNDER
    } stack_op_e;

    // One-cycle result flags of the pop domain
    typedef struct packed {
        logic valid;
        logic under;
        logic over;
    } pop_flags_t;

    // Arriving push is ordered ahead of a local pop in the same cycle
    function automatic stack_op_e pick_op(input logic push_evt,
                                          input logic pop_req,
                                          input logic is_empty,
                                          input logic is_full);
        stack_op_e op;
        if (push_evt && pop_req)
            op = is_full ? OP_DROP_POP : OP_BYPASS;
        else if (push_evt)
            op = is_full ? OP_DROP : OP_PUSH;
        else if (pop_req)
            op = is_empty ? OP_UNDER : OP_POP;
        else
            op = OP_IDLE;
        return op;
    endfunction

    function automatic pop_flags_t flags_of(input stack_op_e op);
        pop_flags_t f;
        f.valid = (op == OP_POP) || (op == OP_DROP_POP) || (op == OP_BYPASS);
        f.under = (op == OP_UNDER);
        f.over  = (op == OP_DROP) || (op == OP_DROP_POP);
        return f;
    endfunction

endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/push_sender.sv
module push_sender #(
    parameter int DATA_W    = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              req_tgl,
    output logic [DATA_W-1:0] hold_data,
    input  logic              ack_tgl_async
);
    logic ack_s;

    toggle_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_async),
        .q   (ack_s)
    );

    // Idle when the returned acknowledge matches the outstanding request
    assign push_ready = (ack_s == req_tgl);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl   <= 1'b0;
            hold_data <= '0;
        end else if (push_req && push_ready) begin
            req_tgl   <= ~req_tgl;
            hold_data <= push_data;
        end
    end
endmodule

// File: rtl/stack_core.sv
module stack_core
    import lifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tgl_async,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              empty,
    output logic              full,
    output logic              underflow,
    output logic              overflow,
    output logic              ack_tgl
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     ptr;
    logic [PW-1:0]     top_idx;
    logic              req_s;
    logic              req_seen;
    logic              push_evt;
    stack_op_e         op;
    pop_flags_t        fl;

    toggle_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl_async),
        .q   (req_s)
    );

    assign push_evt = req_s ^ req_seen;
    assign ack_tgl  = req_seen;
    assign empty    = (ptr == '0);
    assign full     = (ptr == FULL_CNT);
    assign top_idx  = ptr - PW'(1);
    assign op       = pick_op(push_evt, pop_req, empty, full);
    assign fl       = flags_of(op);

    always_ff @(posedge clk) begin
        if (op == OP_PUSH)
            mem[ptr[AW-1:0]] <= hold_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen  <= 1'b0;
            ptr       <= '0;
            pop_data  <= '0;
            pop_valid <= 1'b0;
            underflow <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            req_seen  <= req_s;
            pop_valid <= fl.valid;
            underflow <= fl.under;
            overflow  <= fl.over;
            unique case (op)
                OP_PUSH:     ptr <= ptr + PW'(1);
                OP_POP,
                OP_DROP_POP: begin
                    ptr      <= top_idx;
                    pop_data <= mem[top_idx[AW-1:0]];
                end
                OP_BYPASS:   pop_data <= hold_data;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/dual_clock_stack.sv
module dual_clock_stack #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              empty,
    output logic              full,
    output logic              underflow,
    output logic              overflow
);
    logic              req_tgl;
    logic              ack_tgl;
    logic [DATA_W-1:0] hold_data;

    push_sender #(.DATA_W(DATA_W), .SYNC_STG(SYNC_STG)) u_send (
        .clk           (wr_clk),
        .rst           (wr_rst),
        .push_req      (push_req),
        .push_data     (push_data),
        .push_ready    (push_ready),
        .req_tgl       (req_tgl),
        .hold_data     (hold_data),
        .ack_tgl_async (ack_tgl)
    );

    stack_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STG(SYNC_STG)) u_core (
        .clk           (rd_clk),
        .rst           (rd_rst),
        .req_tgl_async (req_tgl),
        .hold_data     (hold_data),
        .pop_req       (pop_req),
        .pop_data      (pop_data),
        .pop_valid     (pop_valid),
        .empty         (empty),
        .full          (full),
        .underflow     (underflow),
        .overflow      (overflow),
        .ack_tgl       (ack_tgl)
    );
endmodule

// File: rtl/dual_clock_stack_chk.sv
module dual_clock_stack_chk (
    input logic wr_clk,
    input logic wr_rst,
    input logic push_req,
    input logic push_ready,
    input logic rd_clk,
    input logic rd_rst,
    input logic pop_req,
    input logic pop_valid,
    input logic empty,
    input logic full,
    input logic underflow,
    input logic overflow
);
    // R2
    ready_low_after_accept_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (push_req && push_ready) |=> !push_ready);

    // R2
    ready_fall_needs_req_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(push_ready) |-> $past(push_req));

    // R4
    pop_valid_after_req_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        pop_valid |-> $past(pop_req));

    // R5
    underflow_on_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        underflow |-> ($past(empty) && $past(pop_req) && !pop_valid));

    // R6
    overflow_when_full_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        overflow |-> $past(full));

    // R8
    empty_full_excl_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(empty && full));

    // R8
    no_jump_empty_to_full_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $past(empty) |-> !full);
endmodule

bind dual_clock_stack dual_clock_stack_chk u_chk (
    .wr_clk     (wr_clk),
    .wr_rst     (wr_rst),
    .push_req   (push_req),
    .push_ready (push_ready),
    .rd_clk     (rd_clk),
    .rd_rst     (rd_rst),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .empty      (empty),
    .full       (full),
    .underflow  (underflow),
    .overflow   (overflow)
);

// File: tb/dual_clock_stack_test.sv
module dual_clock_stack_test;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst = 1'b1;
    logic              rd_rst = 1'b1;
    logic              push_req = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              pop_req = 1'b0;
    logic              push_ready;
    logic [DATA_W-1:0] pop_data;
    logic              pop_valid, empty, full, underflow, overflow;

    int errors = 0;
    int checks = 0;
    int ov_cnt = 0;
    int uf_cnt = 0;
    int model_q[$];

    always #5    wr_clk = ~wr_clk;   // 100 MHz push side
    always #6.5  rd_clk = ~rd_clk;   // unrelated pop side

    dual_clock_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .push_req(push_req),
        .push_data(push_data), .push_ready(push_ready),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .pop_req(pop_req),
        .pop_data(pop_data), .pop_valid(pop_valid), .empty(empty),
        .full(full), .underflow(underflow), .overflow(overflow)
    );

    always @(negedge rd_clk) begin
        if (!rd_rst && overflow)  ov_cnt++;
        if (!rd_rst && underflow) uf_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Push one word and wait until the stack has applied it
    task automatic do_push(input logic [DATA_W-1:0] d, input bit try_busy);
        @(negedge wr_clk);
        while (!push_ready) @(negedge wr_clk);
        push_req  = 1'b1;
        push_data = d;
        @(negedge wr_clk);
        check(!push_ready, "R2", "ready low after accept", int'(push_ready), 0);
        if (try_busy) begin
            push_data = ~d;          // held high while busy: must be ignored
        end else begin
            push_req = 1'b0;
        end
        @(negedge wr_clk);
        push_req = 1'b0;
        while (!push_ready) @(negedge wr_clk);
        if (model_q.size() < DEPTH) model_q.push_back(int'(d));
    endtask

    // Pop one word and compare against the model
    task automatic do_pop();
        int exp;
        @(negedge rd_clk);
        pop_req = 1'b1;
        @(negedge rd_clk);
        pop_req = 1'b0;
        if (model_q.size() == 0) begin
            check(!pop_valid, "R5", "no valid on empty pop", int'(pop_valid), 0);
            check(underflow, "R5", "underflow pulse", int'(underflow), 1);
        end else begin
            exp = model_q.pop_back();
            check(pop_valid, "R4", "pop_valid strobe", int'(pop_valid), 1);
            check(pop_data == DATA_W'(exp), "R3", "popped word", int'(pop_data), exp);
        end
        @(negedge rd_clk);
        check(!pop_valid, "R4", "strobe lasts one cycle", int'(pop_valid), 0);
        check(empty == (model_q.size() == 0), "R8", "empty flag",
              int'(empty), int'(model_q.size() == 0));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int lat;
        int seen;
        int got;
        bit rose;
        int uf0;
        repeat (4) @(negedge wr_clk);
        wr_rst = 1'b0;
        repeat (4) @(negedge rd_clk);
        rd_rst = 1'b0;
        @(negedge rd_clk);

        // R1 reset state
        check(empty, "R1", "empty after reset", int'(empty), 1);
        check(!full, "R1", "full after reset", int'(full), 0);
        check(!pop_valid && !underflow && !overflow, "R1", "strobes after reset",
              int'({pop_valid, underflow, overflow}), 0);
        check(push_ready, "R1", "push_ready after reset", int'(push_ready), 1);

        // R9 latency from accept to empty falling
        @(negedge wr_clk);
        push_req = 1'b1;
        push_data = 8'h3C;
        @(posedge wr_clk);
        #1 push_req = 1'b0;
        lat = 0;
        while (empty && lat < 20) begin
            @(negedge rd_clk);
            lat++;
        end
        check(lat <= 6, "R9", "push latency in pop cycles", lat, 6);
        while (!push_ready) @(negedge wr_clk);
        model_q.push_back(32'h3C);
        do_pop();

        // R5 pop on empty
        uf0 = uf_cnt;
        do_pop();
        check(uf_cnt == uf0 + 1, "R5", "one underflow pulse", uf_cnt, uf0 + 1);

        // R2 push_req held while busy is ignored
        do_push(8'hA5, 1'b1);
        do_pop();
        do_pop();   // must underflow: the busy request stored nothing

        // R3 order with several patterns
        for (int i = 0; i < 5; i++) do_push(DATA_W'(8'h10 + 8'(i * 7)), 1'b0);
        for (int i = 0; i < 2; i++) do_pop();
        do_push(8'hEE, 1'b0);
        for (int i = 0; i < 4; i++) do_pop();

        // R6 / R8 fill to DEPTH, then overflow
        for (int i = 0; i < DEPTH; i++) do_push(DATA_W'(8'hC0 + 8'(i)), 1'b0);
        @(negedge rd_clk);
        check(full, "R8", "full at DEPTH", int'(full), 1);
        check(!empty, "R8", "not empty when full", int'(empty), 0);
        begin
            int ov0;
            ov0 = ov_cnt;
            do_push(8'h77, 1'b0);   // model ignores it (size == DEPTH)
            repeat (2) @(negedge rd_clk);
            check(ov_cnt == ov0 + 1, "R6", "one overflow pulse", ov_cnt, ov0 + 1);
        end
        check(full, "R6", "still full after dropped push", int'(full), 1);
        for (int i = 0; i < DEPTH; i++) do_pop();
        check(empty, "R8", "empty after draining", int'(empty), 1);

        // R7 push arriving while pop_req is held high on an empty stack
        uf0 = uf_cnt;
        seen = 0;
        got = 0;
        rose = 1'b0;
        fork
            begin
                @(negedge rd_clk);
                pop_req = 1'b1;
                repeat (30) begin
                    @(negedge rd_clk);
                    if (pop_valid) begin
                        seen++;
                        got = int'(pop_data);
                    end
                    if (!empty) rose = 1'b1;
                end
                pop_req = 1'b0;
            end
            begin
                repeat (3) @(negedge wr_clk);
                push_req = 1'b1;
                push_data = 8'h5A;
                @(negedge wr_clk);
                push_req = 1'b0;
            end
        join
        @(negedge rd_clk);
        check(seen == 1, "R7", "one valid word from same-cycle push", seen, 1);
        check(got == 32'h5A, "R7", "word returned is the arriving push", got, 32'h5A);
        check(!rose, "R7", "empty stays high (depth unchanged)", int'(rose), 0);
        check(uf_cnt > uf0, "R5", "underflows before arrival", uf_cnt - uf0, 1);
        while (!push_ready) @(negedge wr_clk);
        check(push_ready, "R2", "ready returns after apply", int'(push_ready), 1);
        do_pop();

        summary();
        $finish;
    end
endmodule